// File: doc/BRIEF.md
# MATS+ March Test Sequencer

This block is a built-in self-test sequencer for a one-bit-wide synchronous RAM of `DEPTH` cells. After a start pulse it takes the RAM's address, write-enable and write-data lines for the whole run. It then performs the three MATS+ march elements in a fixed order. First it fills every cell with 0 in ascending order. Next it walks upward, reading each cell and expecting 0, then writing 1 to it. Last it walks downward, reading each cell and expecting 1, then writing 0 to it. The upward and downward read-then-invert walks are what expose address decoder faults, and the whole run takes 5·`DEPTH` cycles.

The RAM returns read data one cycle after the address is presented. The sequencer therefore spends two cycles on each cell of the second and third elements. In the first cycle it issues the read. In the second it compares the returned bit and writes the inverted value to the same cell. The first mismatch sets a sticky failure state and latches the failing address and the bit that was expected. The run always goes on to the end. A one-cycle done pulse then marks completion, and the pass flag stays valid until the next accepted start. All pins are plain control and status lines with no flow control, since the sequencer owns the memory port outright.

Top module: `mats_plus_bist`

## Requirements
- R1: After synchronous reset, `mem_we`, `done`, `pass`, `fail_addr` and `fail_bit` are all 0 and the sequencer is idle.
- R2: An accepted start is sampled at clock edge 0. In the cycles after edges 0 through DEPTH-1, the sequencer writes 0 (`mem_we`=1, `mem_wdata`=0) to addresses 0, 1, …, DEPTH-1, one per cycle.
- R3: Each cell of the upward element is handled in ascending order over two cycles. The first cycle is a read at the cell (`mem_we`=0). The second cycle writes 1 to the same address. The next read is at address+1.
- R4: Each cell of the downward element is handled in descending order from DEPTH-1 to 0 over two cycles. The first cycle reads the cell. The second cycle writes 0 to the same address. The next read is at address-1.
- R5: `mem_rdata` is compared in the cycle after the read, which is the cycle of the write. The expected bit is 0 in the upward element and 1 in the downward element.
- R6: `done` is high for exactly one cycle, the cycle after edge 5·DEPTH counted from the accepted start. It is low at every other time.
- R7: While `done` is high, and afterwards until the next accepted start, `pass` is 1 if and only if no compare mismatched during the run.
- R8: On the first mismatch of a run, `fail_addr` takes the cell address and `fail_bit` takes the expected bit. Later mismatches in the same run do not change either, and the run still completes.
- R9: A start pulse while a run is in progress is ignored. The run's memory sequence and its done timing are unchanged.
- R10: An accepted start clears `pass`, `fail_addr` and `fail_bit` left over from the previous run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Start pulse; accepted only when idle |
| mem_addr | output | AW | RAM address, AW = clog2(DEPTH) |
| mem_we | output | 1 | RAM write enable; a read when low during a run |
| mem_wdata | output | 1 | RAM write data |
| mem_rdata | input | 1 | RAM read data, valid one cycle after the address |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | No mismatch in the last run; valid from done until next start |
| fail_addr | output | AW | Address of the first mismatch |
| fail_bit | output | 1 | Expected bit at the first mismatch |

## Verification
The assertions check several properties on every cycle. Each read is followed by a write to the same address. Addresses step by +1 after writes of 1 and by -1 after writes of 0 (other than the last write). A run cannot stop early, `done` never lasts two cycles, and the failure record stays fixed once it is taken. Only the bench's scenarios can show that the memory operations come in the exact MATS+ order from the first cycle, that `done` lands exactly 5·DEPTH edges after start, and that the first failure recorded is the right one. For that last point the bench sweeps every stuck-at cell, both polarities and all pairs of faults, and works out the expected first failure address and bit from the order in which the march visits the cells.

// File: rtl/mats_pkg.sv
package mats_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_FILL,
    PH_UP_RD,
    PH_UP_WR,
    PH_DN_RD,
    PH_DN_WR
  } phase_t;
endpackage

// File: rtl/mats_seq.sv
module mats_seq #(
  parameter int DEPTH = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output logic [AW-1:0] addr,
  output logic          we,
  output logic          wdata,
  output logic          chk_en,
  output logic          chk_exp,
  output logic          finish,
  output logic          start_acc
);
  import mats_pkg::*;

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  phase_t ph;
  logic   busy;

  assign busy      = (ph != PH_IDLE);
  assign start_acc = start && !busy;
  assign we        = (ph == PH_FILL) || (ph == PH_UP_WR) || (ph == PH_DN_WR);
  assign wdata     = (ph == PH_UP_WR);
  assign chk_en    = (ph == PH_UP_WR) || (ph == PH_DN_WR);
  assign chk_exp   = (ph == PH_DN_WR);
  assign finish    = (ph == PH_DN_WR) && (addr == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph   <= PH_IDLE;
      addr <= '0;
    end else begin
      unique case (ph)
        PH_IDLE: if (start) begin
          ph   <= PH_FILL;
          addr <= '0;
        end
        PH_FILL: begin
          if (addr == LAST) begin
            ph   <= PH_UP_RD;
            addr <= '0;
          end else begin
            addr <= addr + 1'b1;
          end
        end
        PH_UP_RD: ph <= PH_UP_WR;
        PH_UP_WR: begin
          if (addr == LAST) begin
            ph <= PH_DN_RD;
          end else begin
            ph   <= PH_UP_RD;
            addr <= addr + 1'b1;
          end
        end
        PH_DN_RD: ph <= PH_DN_WR;
        PH_DN_WR: begin
          if (addr == '0) begin
            ph <= PH_IDLE;
          end else begin
            ph   <= PH_DN_RD;
            addr <= addr - 1'b1;
          end
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end

  // R3 / R4: every read during a run is followed by a write to the same cell
  assert_read_then_write_R3: assert property (@(posedge clk) disable iff (rst)
    (busy && !we) |=> (we && addr == $past(addr)));

  // R3: after a write of 1 (not the last cell) the next read is one address up
  assert_up_step_R3: assert property (@(posedge clk) disable iff (rst)
    (we && wdata && chk_en && addr != LAST) |=> (!we && addr == $past(addr) + 1'b1));

  // R4: after a downward write (not cell 0) the next read is one address down
  assert_down_step_R4: assert property (@(posedge clk) disable iff (rst)
    (chk_en && chk_exp && addr != '0) |=> (!we && addr == $past(addr) - 1'b1));

  // R9: a run in progress cannot be cut short or restarted by start
  assert_run_continues_R9: assert property (@(posedge clk) disable iff (rst)
    (busy && !finish) |=> busy);
endmodule

// File: rtl/mats_result.sv
module mats_result #(
  parameter int DEPTH = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_acc,
  input  logic          chk_en,
  input  logic          chk_exp,
  input  logic          rdata,
  input  logic [AW-1:0] addr,
  input  logic          finish,
  output logic          done,
  output logic          pass,
  output logic [AW-1:0] fail_addr,
  output logic          fail_bit
);
  logic fail_q;
  logic mismatch;

  assign mismatch = chk_en && (rdata != chk_exp);

  always_ff @(posedge clk) begin
    if (rst) begin
      done      <= 1'b0;
      pass      <= 1'b0;
      fail_q    <= 1'b0;
      fail_addr <= '0;
      fail_bit  <= 1'b0;
    end else begin
      done <= finish;
      if (start_acc) begin
        pass      <= 1'b0;
        fail_q    <= 1'b0;
        fail_addr <= '0;
        fail_bit  <= 1'b0;
      end else begin
        if (mismatch && !fail_q) begin
          fail_q    <= 1'b1;
          fail_addr <= addr;
          fail_bit  <= chk_exp;
        end
        if (finish) pass <= !(fail_q || mismatch);
      end
    end
  end

  // R6: done is a single-cycle pulse
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8: the first mismatch records the current cell
  assert_first_capture_R8: assert property (@(posedge clk) disable iff (rst)
    (mismatch && !fail_q && !start_acc) |=> (fail_addr == $past(addr) && fail_bit == $past(chk_exp)));

  // R8: once recorded, the failure record holds until the next start
  assert_fail_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (fail_q && !start_acc) |=> (fail_q && $stable(fail_addr) && $stable(fail_bit)));

  // R7: a run with a recorded failure never ends with pass set
  assert_no_pass_on_fail_R7: assert property (@(posedge clk) disable iff (rst)
    (fail_q && finish) |=> !pass);
endmodule

// File: rtl/mats_plus_bist.sv
module mats_plus_bist #(
  parameter int DEPTH = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output logic [AW-1:0] mem_addr,
  output logic          mem_we,
  output logic          mem_wdata,
  input  logic          mem_rdata,
  output logic          done,
  output logic          pass,
  output logic [AW-1:0] fail_addr,
  output logic          fail_bit
);
  logic chk_en;
  logic chk_exp;
  logic finish;
  logic start_acc;

  mats_seq #(.DEPTH(DEPTH)) i_seq (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .addr      (mem_addr),
    .we        (mem_we),
    .wdata     (mem_wdata),
    .chk_en    (chk_en),
    .chk_exp   (chk_exp),
    .finish    (finish),
    .start_acc (start_acc)
  );

  mats_result #(.DEPTH(DEPTH)) i_result (
    .clk       (clk),
    .rst       (rst),
    .start_acc (start_acc),
    .chk_en    (chk_en),
    .chk_exp   (chk_exp),
    .rdata     (mem_rdata),
    .addr      (mem_addr),
    .finish    (finish),
    .done      (done),
    .pass      (pass),
    .fail_addr (fail_addr),
    .fail_bit  (fail_bit)
  );

  // R1: no write is issued in the cycle after reset
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!mem_we && !done && !pass));
endmodule

// File: tb/test_mats_plus_bist.sv
module test_mats_plus_bist;
  localparam int DEPTH = 8;
  localparam int AW = $clog2(DEPTH);
  localparam int OPS = 5 * DEPTH;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [AW-1:0] mem_addr;
  logic          mem_we;
  logic          mem_wdata;
  logic          mem_rdata;
  logic          done;
  logic          pass;
  logic [AW-1:0] fail_addr;
  logic          fail_bit;

  int checks = 0;
  int fails = 0;

  logic [DEPTH-1:0] ram = '0;
  logic [DEPTH-1:0] sa_mask = '0;
  logic [DEPTH-1:0] sa_val = '0;

  always #10 clk = ~clk;

  mats_plus_bist #(.DEPTH(DEPTH)) i_mats_plus_bist (
    .clk(clk), .rst(rst), .start(start),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .done(done), .pass(pass), .fail_addr(fail_addr), .fail_bit(fail_bit)
  );

  // one-bit RAM with one-cycle read latency and stuck-at cells
  always_ff @(posedge clk) begin
    if (mem_we) ram[mem_addr] <= mem_wdata;
    mem_rdata <= sa_mask[mem_addr] ? sa_val[mem_addr] : ram[mem_addr];
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // expected operation k of a run: {we, addr, wdata}
  task automatic exp_op(input int k, output int we, output int ad, output int wd);
    int j;
    if (k < DEPTH) begin
      we = 1; ad = k; wd = 0;
    end else if (k < 3 * DEPTH) begin
      j = k - DEPTH; ad = j / 2; we = j % 2; wd = 1;
    end else begin
      j = k - 3 * DEPTH; ad = DEPTH - 1 - j / 2; we = j % 2; wd = 0;
    end
  endtask

  // runs one test; inputs change at negedge, outputs sampled at negedge
  task automatic run(input bit chk_ops, input int extra_start_at,
                     input bit exp_pass, input int exp_addr, input int exp_bit);
    int we, ad, wd;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R10: previous result cleared once start is accepted
    chk(pass == 1'b0 && fail_addr == '0 && fail_bit == 1'b0, "R10 clear", int'(pass), 0);
    for (int k = 0; k < OPS; k++) begin
      if (chk_ops) begin
        exp_op(k, we, ad, wd);
        chk(int'(mem_we) == we, (k < DEPTH) ? "R2 we" : (k < 3*DEPTH) ? "R3 we" : "R4 we", int'(mem_we), we);
        chk(int'(mem_addr) == ad, (k < DEPTH) ? "R2 addr" : (k < 3*DEPTH) ? "R3 addr" : "R4 addr", int'(mem_addr), ad);
        if (we == 1) chk(int'(mem_wdata) == wd, "R5 wdata", int'(mem_wdata), wd);
      end
      chk(done == 1'b0, "R6 early done", int'(done), 0);
      start = (k == extra_start_at);
      @(negedge clk);
      start = 1'b0;
    end
    chk(done == 1'b1, "R6 done", int'(done), 1);
    chk(pass == exp_pass, "R7 pass", int'(pass), int'(exp_pass));
    if (!exp_pass) begin
      chk(int'(fail_addr) == exp_addr, "R8 fail_addr", int'(fail_addr), exp_addr);
      chk(int'(fail_bit) == exp_bit, "R8 fail_bit", int'(fail_bit), exp_bit);
    end
    @(negedge clk);
    chk(done == 1'b0, "R6 done width", int'(done), 0);
    chk(pass == exp_pass, "R7 pass held", int'(pass), int'(exp_pass));
    chk(mem_we == 1'b0, "R9 idle after run", int'(mem_we), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int ea, eb;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(mem_we == 1'b0 && done == 1'b0, "R1 we/done", int'(mem_we) + int'(done), 0);
    chk(pass == 1'b0 && fail_addr == '0 && fail_bit == 1'b0, "R1 flags", int'(pass), 0);

    // fault-free run with full operation trace (R2..R6)
    run(1'b1, -1, 1'b1, 0, 0);
    // R9: start in the middle of a run is ignored
    run(1'b1, 11, 1'b1, 0, 0);

    // every single stuck-at cell, both polarities
    for (int c = 0; c < DEPTH; c++) begin
      for (int v = 0; v < 2; v++) begin
        sa_mask = '0; sa_mask[c] = 1'b1;
        sa_val = '0; sa_val[c] = v[0];
        run(1'b0, -1, 1'b0, c, (v == 1) ? 0 : 1);
      end
    end

    // all pairs of stuck cells: first failure follows march visit order (R8)
    for (int a = 0; a < DEPTH; a++) begin
      for (int b = 0; b < DEPTH; b++) begin
        if (a == b) continue;
        for (int p = 0; p < 4; p++) begin
          sa_mask = '0; sa_mask[a] = 1'b1; sa_mask[b] = 1'b1;
          sa_val = '0; sa_val[a] = p[0]; sa_val[b] = p[1];
          ea = -1;
          for (int c = 0; c < DEPTH; c++)
            if (ea < 0 && sa_mask[c] && sa_val[c]) ea = c;
          if (ea >= 0) eb = 0;
          else begin
            for (int c = 0; c < DEPTH; c++)
              if (sa_mask[c]) ea = c;
            eb = 1;
          end
          run(1'b0, (a == 0) ? 5 : -1, 1'b0, ea, eb);
        end
      end
    end

    // healthy memory again: previous failure cleared, pass restored (R10, R7)
    sa_mask = '0;
    run(1'b1, -1, 1'b1, 0, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule